// File: doc/BRIEF.md
# Memory Window Base Registers with Size Discovery

This block holds the six base-address slots of an endpoint-style configuration header. Configuration software writes and reads them through a simple dword-addressed port. Each slot is fixed at build time through parameters. A slot is either in use or not. If in use, it is a memory window whose size is a power of two, decoded as 32-bit or 64-bit, and prefetchable or not.

Address bits that fall inside the window are wired to zero. Software can therefore learn the window size by writing all ones to a slot and reading it back. It then programs the real base address. A 64-bit window uses an even slot for its low half and the next slot for its high half.

For each window, the block compares an incoming 64-bit memory address against the programmed base, masked to the window size. It raises a hit flag for that window when the address falls inside it and memory decoding is enabled.

Top module: `bar_bank`

## Requirements
- R1: The six slots sit at byte offsets 10h, 14h, 18h, 1Ch, 20h and 24h, in slot order 0 to 5. A read of any other offset returns zero, and a write to any other offset changes no slot.
- R2: After reset every programmable base bit is zero, so each slot reads back only its fixed type bits.
- R3: Every slot in use, except the high half of a 64-bit window, reads back fixed low bits. Bit 0 is 0 (memory space). Bits 2:1 are 10 for a 64-bit window and 00 for a 32-bit window. Bit 3 is 1 when the window is prefetchable. Writes never change these bits.
- R4: After all ones are written, a slot reads back ones in every base bit at or above log2(window size) and zeros below it, apart from the R3 type bits.
- R5: A slot that is not in use reads as zero and ignores all writes.
- R6: A 64-bit window may start only at slot 0, 2 or 4. The next slot then holds address bits 63:32, which are writable above the window size. A 64-bit request on an odd slot is treated as 32-bit.
- R7: On a write, byte lane k (bits 8k+7:8k) is updated only when byte-enable bit k is 1.
- R8: Hit bit s, where s is the low slot of a window, is 1 in the same cycle when the memory-decode enable is 1 and the request address masked to the window size equals the programmed base. Hit bits of high-half slots and slots not in use are always 0.
- R9: A 32-bit window hits only when request address bits 63:32 are zero.
- R10: While the memory-decode enable is 0, all hit bits are 0.
- R11: A window size below 128 bytes (log2 below 7) is raised to 128 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Write byte enables |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| mem_space_en | input | 1 | Memory-decode enable |
| req_addr | input | 64 | Memory request address |
| bar_hit | output | 6 | Per-slot window hit flags |

## Verification
A wrong base bit in this block shows up on the same read in two ways. It appears on cfg_rdata as soon as the slot is read back. It also changes bar_hit in the cycle after the write that corrupted it, because the compare uses the live register contents.

A wrong writable mask shows up only after an all-ones write, as a size value that differs from the one the parameters set. For that reason every configured slot is sized and then read back, and every slot is probed with addresses just inside and just outside its window.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int NSLOT  = 6;
  localparam int LOG2_W = 6;
  localparam int MIN_LOG2 = 7;

  typedef logic [NSLOT-1:0]             slot_vec_t;
  typedef logic [NSLOT-1:0][LOG2_W-1:0] slot_log2_t;

  function automatic bit is_low64(int s, slot_vec_t en, slot_vec_t is64);
    return (s % 2 == 0) && (s < NSLOT - 1) && en[s] && is64[s];
  endfunction

  function automatic bit is_high64(int s, slot_vec_t en, slot_vec_t is64);
    return (s % 2 == 1) && is_low64(s - 1, en, is64);
  endfunction

  function automatic logic [63:0] win_mask(int lg);
    int e;
    e = (lg < MIN_LOG2) ? MIN_LOG2 : lg;
    return ~64'd0 << e;
  endfunction

  function automatic logic [31:0] slot_wmask(int s, slot_vec_t en, slot_vec_t is64,
                                             slot_log2_t lg);
    logic [63:0] m;
    if (is_high64(s, en, is64)) begin
      m = win_mask(int'(lg[s-1]));
      return m[63:32];
    end
    if (!en[s]) return 32'd0;
    m = win_mask(int'(lg[s]));
    return m[31:0];
  endfunction

  function automatic logic [31:0] slot_ro(int s, slot_vec_t en, slot_vec_t is64,
                                          slot_vec_t pref);
    if (is_high64(s, en, is64) || !en[s]) return 32'd0;
    return {28'd0, pref[s], is_low64(s, en, is64) ? 2'b10 : 2'b00, 1'b0};
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot #(
  parameter logic [31:0] WMASK = 32'hFFFF_FF80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] q
);
  logic [31:0] lane_m;
  logic [31:0] q_nx;

  always_comb begin
    for (int k = 0; k < 4; k++) lane_m[8*k +: 8] = {8{be[k]}};
    lane_m = lane_m & WMASK;
    q_nx   = (q & ~lane_m) | (wdata & lane_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_nx;
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  p_lane_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~$past(lane_m)) == ($past(q) & ~$past(lane_m))));
  p_lane_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(lane_m)) == ($past(wdata) & $past(lane_m))));
endmodule

// File: rtl/bar_match.sv
module bar_match #(
  parameter logic [63:0] CMASK = 64'hFFFF_FFFF_FFFF_FF80
) (
  input  logic        dec_en,
  input  logic [63:0] base,
  input  logic [63:0] addr,
  output logic        hit
);
  always_comb hit = dec_en && ((addr & CMASK) == (base & CMASK));
endmodule

// File: rtl/bar_bank.sv
module bar_bank
  import bar_pkg::*;
#(
  parameter int         CFG_AW    = 12,
  parameter slot_vec_t  SLOT_EN   = 6'b010101,
  parameter slot_vec_t  SLOT_IS64 = 6'b000001,
  parameter slot_vec_t  SLOT_PREF = 6'b010001,
  parameter slot_log2_t SLOT_LOG2 = {6'd0, 6'd20, 6'd0, 6'd4, 6'd0, 6'd12}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic [31:0]       cfg_rdata,
  input  logic              mem_space_en,
  input  logic [63:0]       req_addr,
  output logic [NSLOT-1:0]  bar_hit
);
  localparam int DW_W = CFG_AW - 2;
  localparam logic [DW_W-1:0] BAR_DW0 = DW_W'(4);

  logic [DW_W-1:0]  dw;
  logic [DW_W-1:0]  rel;
  logic             in_win;
  logic [31:0]      q   [NSLOT];
  logic [31:0]      rdv [NSLOT];
  logic [NSLOT-1:0] wsel;

  always_comb begin
    dw     = cfg_addr[CFG_AW-1:2];
    rel    = dw - BAR_DW0;
    in_win = (dw >= BAR_DW0) && (rel < DW_W'(NSLOT));
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [31:0] WM = slot_wmask(s, SLOT_EN, SLOT_IS64, SLOT_LOG2);
    localparam logic [31:0] RO = slot_ro(s, SLOT_EN, SLOT_IS64, SLOT_PREF);

    assign wsel[s] = cfg_wr_en && in_win && (rel == DW_W'(s));

    bar_slot #(.WMASK(WM)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wsel[s]),
      .wdata(cfg_wdata), .be(cfg_be), .q(q[s]));

    assign rdv[s] = q[s] | RO;

    if (is_low64(s, SLOT_EN, SLOT_IS64)) begin : g_w64
      localparam logic [63:0] CM = win_mask(int'(SLOT_LOG2[s]));
      bar_match #(.CMASK(CM)) u_match (
        .dec_en(mem_space_en), .base({q[s+1], q[s]}),
        .addr(req_addr), .hit(bar_hit[s]));
    end else if (SLOT_EN[s] && !is_high64(s, SLOT_EN, SLOT_IS64)) begin : g_w32
      localparam logic [63:0] WMF = win_mask(int'(SLOT_LOG2[s]));
      localparam logic [63:0] CM  = {32'hFFFF_FFFF, WMF[31:0]};
      bar_match #(.CMASK(CM)) u_match (
        .dec_en(mem_space_en), .base({32'd0, q[s]}),
        .addr(req_addr), .hit(bar_hit[s]));
    end else begin : g_none
      assign bar_hit[s] = 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int s = 0; s < NSLOT; s++)
      if (in_win && rel == DW_W'(s)) cfg_rdata = rdv[s];
  end

  p_dec_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_space_en |-> (bar_hit == '0));
  p_outside_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (cfg_rdata == 32'd0));
  p_wsel_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && rel == DW_W'(3)) |-> (cfg_rdata == 32'd0));
endmodule

// File: tb/bar_bank_tb.sv
module bar_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        mem_space_en = 1'b0;
  logic [63:0] req_addr = '0;
  logic [5:0]  bar_hit;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bar_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .mem_space_en(mem_space_en), .req_addr(req_addr), .bar_hit(bar_hit));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = b; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic hit_chk(string req, logic [63:0] a, logic [5:0] exp);
    @(negedge clk);
    req_addr = a;
    #1 chk(req, 64'(bar_hit), 64'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R2 R3 slot0", 12'h010, 32'h0000_000C);
    rd_chk("R2 slot1",    12'h014, 32'h0);
    rd_chk("R2 slot2",    12'h018, 32'h0);
    rd_chk("R2 R3 slot4", 12'h020, 32'h0000_0008);
  endtask

  task automatic t_sizing();
    do_reset();
    for (int s = 0; s < 6; s++) wr(12'(16 + 4*s), 32'hFFFF_FFFF, 4'hF);
    rd_chk("R4 R3 slot0 64b 4K",  12'h010, 32'hFFFF_F00C);
    rd_chk("R6 slot1 high half",  12'h014, 32'hFFFF_FFFF);
    rd_chk("R11 R4 slot2 clamp",  12'h018, 32'hFFFF_FF80);
    rd_chk("R5 slot3 unused",     12'h01C, 32'h0);
    rd_chk("R4 R3 slot4 1M pref", 12'h020, 32'hFFF0_0008);
    rd_chk("R5 slot5 unused",     12'h024, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
    wr(12'h028, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R1 offset 0Ch", 12'h00C, 32'h0);
    rd_chk("R1 offset 28h", 12'h028, 32'h0);
  endtask

  task automatic t_outside_write();
    do_reset();
    wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
    wr(12'h028, 32'hFFFF_FFFF, 4'hF);
    wr(12'h110, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R1 slot0 untouched", 12'h010, 32'h0000_000C);
    rd_chk("R1 slot2 untouched", 12'h018, 32'h0);
    rd_chk("R1 slot4 untouched", 12'h020, 32'h0000_0008);
  endtask

  task automatic t_byte_en();
    do_reset();
    wr(12'h020, 32'hFFFF_FFFF, 4'b1000);
    rd_chk("R7 lane3 only", 12'h020, 32'hFF00_0008);
    wr(12'h020, 32'h00FF_FFFF, 4'b0100);
    rd_chk("R7 lane2 add", 12'h020, 32'hFFF0_0008);
    wr(12'h020, 32'h0000_0000, 4'b0011);
    rd_chk("R7 R3 lanes1-0 no effect", 12'h020, 32'hFFF0_0008);
  endtask

  task automatic t_hits();
    do_reset();
    wr(12'h010, 32'h1234_5000, 4'hF);
    wr(12'h014, 32'h0000_0001, 4'hF);
    wr(12'h018, 32'hABCD_0080, 4'hF);
    wr(12'h020, 32'h8000_0000, 4'hF);
    rd_chk("R6 slot0 base", 12'h010, 32'h1234_500C);
    rd_chk("R4 slot2 base", 12'h018, 32'hABCD_0080);
    mem_space_en = 1'b1;
    hit_chk("R8 R6 64b inside",   64'h1_1234_5ABC, 6'b000001);
    hit_chk("R8 64b past end",    64'h1_1234_6000, 6'b000000);
    hit_chk("R6 64b wrong high",  64'h0_1234_5ABC, 6'b000000);
    hit_chk("R8 R11 32b inside",  64'h0_ABCD_00FF, 6'b000100);
    hit_chk("R11 32b past 128B",  64'h0_ABCD_0100, 6'b000000);
    hit_chk("R9 32b high nonzero", 64'h1_ABCD_0080, 6'b000000);
    hit_chk("R8 1M top edge",     64'h0_800F_FFFF, 6'b010000);
    hit_chk("R8 1M past end",     64'h0_8010_0000, 6'b000000);
    mem_space_en = 1'b0;
    hit_chk("R10 decode off", 64'h1_1234_5ABC, 6'b000000);
    hit_chk("R10 decode off 32b", 64'h0_ABCD_0080, 6'b000000);
  endtask

  initial begin
    t_reset();
    t_sizing();
    t_outside_write();
    t_byte_en();
    t_hits();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule